// File: doc/BRIEF.md
# Configurable Endianness Bus Adapter

This block joins a 32-bit load/store port and an instruction-fetch port on the processor side to two little-endian 32-bit memory ports, one for data and one for fetch. A two-bit mode chooses how multi-byte values are laid out in memory. In little-endian mode the low-order byte goes to the lowest address. In the word-invariant big-endian mode, full words pass unchanged and sub-word accesses reach their bytes through inverted low address bits. In the byte-invariant big-endian mode, bytes keep their address and halfword and word data are byte-reversed.

On the data side the block works out the byte strobes, places write data on the lanes, and on reads pulls the selected lanes back together and zero- or sign-extends them. Instruction fetches follow their own rule: the instruction image is kept little-endian, so fetched data is never byte-reversed, even in the byte-invariant mode. The path from request to memory is combinational. One register stage holds the lane plan of a read so that it meets memory data that returns one cycle later. Misaligned requests are flagged and never reach memory.

Top module: `endian_bridge`

## Requirements
- R1: The mode is encoded as 00 little-endian, 01 word-invariant big-endian, 10 byte-invariant big-endian. In little-endian mode, byte k of a stored value (byte 0 being bits 7:0) goes to lane (addr[1:0]+k) mod 4, where lane n is m_wdata_o bits 8n+7:8n and m_be_o bit n.
- R2: In byte-invariant mode a byte store uses lane addr[1:0] unchanged. A halfword or word store puts its most significant byte at the lowest address, so the register word 32'h12345678 appears on m_wdata_o as 32'h78563412, and loading it back returns 32'h12345678.
- R3: In word-invariant mode a word passes through unreversed. A byte access uses lane addr[1:0] XOR 3, a halfword uses base lane addr[1:0] XOR 2, and bytes are never reversed within the access.
- R4: d_size_i encodes 0 byte, 1 halfword, 2 word. An accepted access asserts exactly 1, 2 or 4 adjacent strobes, drives m_addr_o as the request address with bits 1:0 cleared, and writes zero on lanes without a strobe.
- R5: A read accepted in cycle t gives d_rvalid_o high in cycle t+1 with the value pulled from m_rdata_i by the inverse of the store mapping. When d_signed_i was 1 the value is sign-extended from the top accessed byte, otherwise it is zero-extended.
- R6: A halfword with addr[0]=1, a word with addr[1:0]!=0, or size code 3 raises d_misalign_o in the same cycle, keeps m_req_o low with no strobes, and produces no d_rvalid_o.
- R7: A word fetch (f_half_i=0) returns the memory word unchanged in every mode. A halfword fetch takes lanes {addr[1],0} and +1 in little-endian and byte-invariant modes, and base lane (addr[1:0] XOR 2) in word-invariant mode, never reversed and zero-extended. The result arrives with f_ivalid_o one cycle after i_req_o. A misaligned fetch raises f_misalign_o and issues no i_req_o.
- R8: mode_i is taken at a clock edge only when neither port requests in that cycle and no response is due in it. The new mode governs requests from the next cycle on, and mode 11 acts as little-endian.
- R9: After reset both valid outputs and both memory requests are low and the mode in force is little-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Endianness mode select |
| d_req_i | input | 1 | Data access request |
| d_we_i | input | 1 | Data access is a store |
| d_size_i | input | 2 | Data access size code |
| d_signed_i | input | 1 | Sign-extend the load result |
| d_addr_i | input | ADDR_W | Data byte address |
| d_wdata_i | input | DATA_W | Store value, right-justified |
| d_rdata_o | output | DATA_W | Load result |
| d_rvalid_o | output | 1 | Load result valid |
| d_misalign_o | output | 1 | Data access misaligned or illegal |
| f_req_i | input | 1 | Instruction fetch request |
| f_half_i | input | 1 | Fetch is a halfword |
| f_addr_i | input | ADDR_W | Fetch byte address |
| f_instr_o | output | DATA_W | Fetched instruction |
| f_ivalid_o | output | 1 | Fetched instruction valid |
| f_misalign_o | output | 1 | Fetch misaligned |
| m_req_o | output | 1 | Data memory request |
| m_we_o | output | 1 | Data memory write |
| m_addr_o | output | ADDR_W | Data memory word address |
| m_be_o | output | 4 | Data memory byte strobes |
| m_wdata_o | output | DATA_W | Data memory write data |
| m_rdata_i | input | DATA_W | Data memory read data, one cycle after request |
| i_req_o | output | 1 | Fetch memory request |
| i_addr_o | output | ADDR_W | Fetch memory word address |
| i_rdata_i | input | DATA_W | Fetch memory read data, one cycle after request |

## Verification
A data load and an instruction fetch can be in flight together and return in the same cycle, yet only the load is byte-reversed in the byte-invariant mode. The bench issues both to the same word in one cycle and expects the load to give the register order and the fetch the raw memory order. A mode change can also arrive while a load is still due. The bench changes mode_i in request cycles and in response cycles, and the behavioural model only moves its own mode in truly idle cycles, so a change taken too early shows up as wrong strobes or data on a later access.

// File: rtl/endian_pkg.sv
package endian_pkg;
   localparam int LANES  = 4;
   localparam int LANE_W = $clog2(LANES);
   localparam int NB_W   = LANE_W + 1;

   typedef enum logic [1:0] {
      END_LITTLE   = 2'b00,
      END_BIG_WORD = 2'b01,
      END_BIG_BYTE = 2'b10,
      END_SPARE    = 2'b11
   } endian_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_SPARE = 2'd3
   } acc_size_e;

   // Where an access sits on the lanes and how its bytes are ordered
   typedef struct packed {
      logic [LANE_W-1:0] base;
      logic [NB_W-1:0]   nbytes;
      logic              rev;
      logic              err;
   } lane_plan_t;
endpackage

// File: rtl/endian_lane_ctl.sv
module endian_lane_ctl
   import endian_pkg::*;
#(
   parameter bit FETCH_PATH = 1'b0
) (
   input  logic [1:0]        mode_i,
   input  logic [1:0]        size_i,
   input  logic [LANE_W-1:0] offs_i,
   output lane_plan_t        plan_o
);
   logic [LANE_W-1:0] flip;
   logic              bad;
   logic              rev;

   always_comb begin
      unique case (size_i)
         SZ_BYTE: bad = 1'b0;
         SZ_HALF: bad = offs_i[0];
         SZ_WORD: bad = |offs_i;
         default: bad = 1'b1;
      endcase
   end

   // word-invariant mode reaches sub-word data by mirroring the offset
   always_comb begin
      flip = '0;
      if (mode_i == END_BIG_WORD) begin
         if (size_i == SZ_BYTE)
            flip = LANE_W'(LANES - 1);
         else if (size_i == SZ_HALF)
            flip = LANE_W'(LANES - 2);
      end
   end

   generate
      if (FETCH_PATH) begin : g_fetch
         // instruction image stays little-endian: never reversed
         assign rev = 1'b0;
      end else begin : g_data
         assign rev = (mode_i == END_BIG_BYTE) && (size_i != SZ_BYTE);
      end
   endgenerate

   assign plan_o.base   = offs_i ^ flip;
   assign plan_o.nbytes = NB_W'(1) << size_i;
   assign plan_o.rev    = rev;
   assign plan_o.err    = bad;
endmodule

// File: rtl/endian_wr_steer.sv
module endian_wr_steer
   import endian_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  lane_plan_t        plan_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [LANES-1:0]  be_o,
   output logic [DATA_W-1:0] data_o
);
   generate
      for (genvar L = 0; L < LANES; L++) begin : g_lane
         logic [LANE_W-1:0] rel;
         logic [LANE_W-1:0] pick;
         logic              hit;

         assign rel  = LANE_W'(L) - plan_i.base;
         assign hit  = ({1'b0, rel} < plan_i.nbytes);
         assign pick = plan_i.rev ? (LANE_W'(plan_i.nbytes - NB_W'(1)) - rel) : rel;

         assign be_o[L]            = hit;
         assign data_o[8*L +: 8]   = hit ? data_i[8*pick +: 8] : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/endian_rd_pack.sv
module endian_rd_pack
   import endian_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit HAS_SEXT = 1'b1
) (
   input  lane_plan_t        plan_i,
   input  logic              sext_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] packed_v;
   logic              top_bit;
   logic              fill;

   always_comb begin
      packed_v = '0;
      for (int k = 0; k < LANES; k++) begin
         logic [LANE_W-1:0] src;
         if (plan_i.rev)
            src = plan_i.base + LANE_W'(plan_i.nbytes - NB_W'(1)) - LANE_W'(k);
         else
            src = plan_i.base + LANE_W'(k);
         if (NB_W'(k) < plan_i.nbytes)
            packed_v[8*k +: 8] = data_i[8*src +: 8];
      end
   end

   always_comb begin
      top_bit = 1'b0;
      for (int k = 1; k <= LANES; k++) begin
         if (NB_W'(k) == plan_i.nbytes)
            top_bit = packed_v[8*k-1];
      end
   end

   generate
      if (HAS_SEXT) begin : g_sext
         assign fill = sext_i & top_bit;
      end else begin : g_zext
         assign fill = 1'b0;
      end
   endgenerate

   always_comb begin
      data_o = packed_v;
      for (int i = 0; i < DATA_W; i++) begin
         if (i >= 8*int'(plan_i.nbytes))
            data_o[i] = fill;
      end
   end
endmodule

// File: rtl/endian_bridge.sv
module endian_bridge
   import endian_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              d_req_i,
   input  logic              d_we_i,
   input  logic [1:0]        d_size_i,
   input  logic              d_signed_i,
   input  logic [ADDR_W-1:0] d_addr_i,
   input  logic [DATA_W-1:0] d_wdata_i,
   output logic [DATA_W-1:0] d_rdata_o,
   output logic              d_rvalid_o,
   output logic              d_misalign_o,
   input  logic              f_req_i,
   input  logic              f_half_i,
   input  logic [ADDR_W-1:0] f_addr_i,
   output logic [DATA_W-1:0] f_instr_o,
   output logic              f_ivalid_o,
   output logic              f_misalign_o,
   output logic              m_req_o,
   output logic              m_we_o,
   output logic [ADDR_W-1:0] m_addr_o,
   output logic [3:0]        m_be_o,
   output logic [DATA_W-1:0] m_wdata_o,
   input  logic [DATA_W-1:0] m_rdata_i,
   output logic              i_req_o,
   output logic [ADDR_W-1:0] i_addr_o,
   input  logic [DATA_W-1:0] i_rdata_i
);
   generate
      if (DATA_W != 8*LANES) begin : g_bad_data_w
         $error("endian_bridge: DATA_W must equal 8*LANES");
      end
      if (ADDR_W <= LANE_W) begin : g_bad_addr_w
         $error("endian_bridge: ADDR_W too narrow");
      end
   endgenerate

   logic [1:0]        mode_q;
   logic              d_pend_q, f_pend_q;
   lane_plan_t        d_plan, f_plan, d_plan_q, f_plan_q;
   logic              d_sext_q;
   logic [LANES-1:0]  d_be;
   logic [DATA_W-1:0] d_wlane, d_rword, f_rword;
   logic              busy;
   logic [1:0]        f_size;

   // ---------------- mode register ----------------
   assign busy = d_req_i | f_req_i | d_pend_q | f_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= END_LITTLE;
      else if (!busy)
         mode_q <= mode_i;
   end

   // ---------------- data side ----------------
   endian_lane_ctl #(.FETCH_PATH(1'b0)) u_d_ctl (
      .mode_i (mode_q),
      .size_i (d_size_i),
      .offs_i (d_addr_i[LANE_W-1:0]),
      .plan_o (d_plan)
   );

   endian_wr_steer #(.DATA_W(DATA_W)) u_d_wr (
      .plan_i (d_plan),
      .data_i (d_wdata_i),
      .be_o   (d_be),
      .data_o (d_wlane)
   );

   assign d_misalign_o = d_req_i & d_plan.err;
   assign m_req_o      = d_req_i & ~d_plan.err;
   assign m_we_o       = m_req_o & d_we_i;
   assign m_addr_o     = {d_addr_i[ADDR_W-1:LANE_W], LANE_W'(0)};
   assign m_be_o       = m_req_o ? d_be : '0;
   assign m_wdata_o    = m_we_o ? d_wlane : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_pend_q <= 1'b0;
         d_plan_q <= '0;
         d_sext_q <= 1'b0;
      end else begin
         d_pend_q <= m_req_o & ~d_we_i;
         if (m_req_o & ~d_we_i) begin
            d_plan_q <= d_plan;
            d_sext_q <= d_signed_i;
         end
      end
   end

   endian_rd_pack #(.DATA_W(DATA_W), .HAS_SEXT(1'b1)) u_d_rd (
      .plan_i (d_plan_q),
      .sext_i (d_sext_q),
      .data_i (m_rdata_i),
      .data_o (d_rword)
   );

   assign d_rvalid_o = d_pend_q;
   assign d_rdata_o  = d_pend_q ? d_rword : '0;

   // ---------------- fetch side ----------------
   assign f_size = f_half_i ? SZ_HALF : SZ_WORD;

   endian_lane_ctl #(.FETCH_PATH(1'b1)) u_f_ctl (
      .mode_i (mode_q),
      .size_i (f_size),
      .offs_i (f_addr_i[LANE_W-1:0]),
      .plan_o (f_plan)
   );

   assign f_misalign_o = f_req_i & f_plan.err;
   assign i_req_o      = f_req_i & ~f_plan.err;
   assign i_addr_o     = {f_addr_i[ADDR_W-1:LANE_W], LANE_W'(0)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_pend_q <= 1'b0;
         f_plan_q <= '0;
      end else begin
         f_pend_q <= i_req_o;
         if (i_req_o)
            f_plan_q <= f_plan;
      end
   end

   endian_rd_pack #(.DATA_W(DATA_W), .HAS_SEXT(1'b0)) u_f_rd (
      .plan_i (f_plan_q),
      .sext_i (1'b0),
      .data_i (i_rdata_i),
      .data_o (f_rword)
   );

   assign f_ivalid_o = f_pend_q;
   assign f_instr_o  = f_pend_q ? f_rword : '0;
endmodule

// File: rtl/endian_bridge_chk.sv
module endian_bridge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       d_req_i,
   input logic [1:0] d_size_i,
   input logic       d_misalign_o,
   input logic       d_rvalid_o,
   input logic       f_req_i,
   input logic       f_misalign_o,
   input logic       f_ivalid_o,
   input logic       m_req_o,
   input logic       m_we_o,
   input logic [3:0] m_be_o,
   input logic       i_req_o,
   input logic [1:0] mode_q,
   input logic       d_pend_q,
   input logic       f_pend_q
);
   // R6: a flagged data access never reaches memory
   a_r6_no_mem_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req_i && d_misalign_o) |-> (!m_req_o && m_be_o == 4'b0000));

   // R4: strobe count follows the access size
   a_r4_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
      m_req_o |-> ($countones(m_be_o) == (1 << d_size_i)));

   // R5: an accepted load answers in the next cycle
   a_r5_load_answers: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req_o && !m_we_o) |=> d_rvalid_o);

   // R5: no load result without a load request one cycle before
   a_r5_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      d_rvalid_o |-> $past(m_req_o && !m_we_o));

   // R7: fetch answers one cycle after its memory request
   a_r7_fetch_answers: assert property (@(posedge clk) disable iff (!rst_n)
      i_req_o |=> f_ivalid_o);

   // R7: a misaligned fetch issues no memory request
   a_r7_no_fetch_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
      (f_req_i && f_misalign_o) |-> !i_req_o);

   // R8: mode is held across any cycle with traffic or a due response
   a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req_i || f_req_i || d_pend_q || f_pend_q) |=> $stable(mode_q));
endmodule

bind endian_bridge endian_bridge_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .d_req_i      (d_req_i),
   .d_size_i     (d_size_i),
   .d_misalign_o (d_misalign_o),
   .d_rvalid_o   (d_rvalid_o),
   .f_req_i      (f_req_i),
   .f_misalign_o (f_misalign_o),
   .f_ivalid_o   (f_ivalid_o),
   .m_req_o      (m_req_o),
   .m_we_o       (m_we_o),
   .m_be_o       (m_be_o),
   .i_req_o      (i_req_o),
   .mode_q       (mode_q),
   .d_pend_q     (d_pend_q),
   .f_pend_q     (f_pend_q)
);

// File: tb/endian_bridge_tb_top.sv
`timescale 1ns/1ps
module endian_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode_i;
   logic        d_req_i, d_we_i, d_signed_i;
   logic [1:0]  d_size_i;
   logic [31:0] d_addr_i, d_wdata_i, d_rdata_o;
   logic        d_rvalid_o, d_misalign_o;
   logic        f_req_i, f_half_i;
   logic [31:0] f_addr_i, f_instr_o;
   logic        f_ivalid_o, f_misalign_o;
   logic        m_req_o, m_we_o;
   logic [31:0] m_addr_o, m_wdata_o, m_rdata_i;
   logic [3:0]  m_be_o;
   logic        i_req_o;
   logic [31:0] i_addr_o, i_rdata_i;

   always #2.5 clk = ~clk;

   endian_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .d_req_i(d_req_i), .d_we_i(d_we_i), .d_size_i(d_size_i), .d_signed_i(d_signed_i),
      .d_addr_i(d_addr_i), .d_wdata_i(d_wdata_i), .d_rdata_o(d_rdata_o),
      .d_rvalid_o(d_rvalid_o), .d_misalign_o(d_misalign_o),
      .f_req_i(f_req_i), .f_half_i(f_half_i), .f_addr_i(f_addr_i),
      .f_instr_o(f_instr_o), .f_ivalid_o(f_ivalid_o), .f_misalign_o(f_misalign_o),
      .m_req_o(m_req_o), .m_we_o(m_we_o), .m_addr_o(m_addr_o), .m_be_o(m_be_o),
      .m_wdata_o(m_wdata_o), .m_rdata_i(m_rdata_i),
      .i_req_o(i_req_o), .i_addr_o(i_addr_o), .i_rdata_i(i_rdata_i)
   );

   // memory environment: 16 words, one-cycle read latency
   logic [31:0] mem [0:15];
   always @(posedge clk) begin
      if (m_req_o) begin
         if (m_we_o) begin
            for (int b = 0; b < 4; b++)
               if (m_be_o[b]) mem[m_addr_o[5:2]][8*b +: 8] <= m_wdata_o[8*b +: 8];
         end else begin
            m_rdata_i <= mem[m_addr_o[5:2]];
         end
      end
      if (i_req_o) i_rdata_i <= mem[i_addr_o[5:2]];
   end

   int n_chk = 0, n_fail = 0;
   int exp_mode = 0;
   bit pend_d = 0, pend_f = 0;
   logic [31:0] exp_d, exp_f;
   bit done = 0;

   task automatic report();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // lane holding byte k of an access, derived from the mode rules
   function automatic int lane_of(int m, int sz, int a, int k, bit fetch);
      int n = 1 << sz;
      int off = a & 3;
      int idx = k;
      if (m == 1) begin
         if (sz == 0) off = off ^ 3;
         else if (sz == 1) off = off ^ 2;
      end
      if (m == 2 && !fetch && sz != 0) idx = n - 1 - k;
      return (off + idx) & 3;
   endfunction

   function automatic bit is_bad(int sz, int a);
      return (sz == 3) || (sz == 1 && (a & 1) != 0) || (sz == 2 && (a & 3) != 0);
   endfunction

   function automatic logic [31:0] ref_be(int m, int sz, int a);
      logic [31:0] r = '0;
      for (int k = 0; k < (1 << sz); k++) r[lane_of(m, sz, a, k, 0)] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] ref_wd(int m, int sz, int a, logic [31:0] v);
      logic [31:0] r = '0;
      for (int k = 0; k < (1 << sz); k++) r[8*lane_of(m, sz, a, k, 0) +: 8] = v[8*k +: 8];
      return r;
   endfunction

   function automatic logic [31:0] ref_ld(int m, int sz, int a, bit sg, logic [31:0] w, bit fetch);
      logic [31:0] r = '0;
      int n = 1 << sz;
      for (int k = 0; k < n; k++) r[8*k +: 8] = w[8*lane_of(m, sz, a, k, fetch) +: 8];
      if (sg && r[8*n-1])
         for (int i = 8*n; i < 32; i++) r[i] = 1'b1;
      return r;
   endfunction

   // one bench cycle, entered and left at a falling edge
   task automatic step(input int mode, input bit dreq, input bit we, input int sz, input int addr,
                       input logic [31:0] wd, input bit sg, input bit freq, input bit fh, input int faddr);
      bit prev_busy, bad, go, fbad, fgo;
      int m, fsz;
      string wtag;
      chk_eq("R5 load valid", {31'b0, d_rvalid_o}, {31'b0, pend_d});
      if (pend_d) chk_eq("R5 load data", d_rdata_o, exp_d);
      chk_eq("R7 fetch valid", {31'b0, f_ivalid_o}, {31'b0, pend_f});
      if (pend_f) chk_eq("R7 fetch data", f_instr_o, exp_f);
      prev_busy = pend_d | pend_f;

      mode_i = 2'(mode); d_req_i = dreq; d_we_i = we; d_size_i = 2'(sz);
      d_addr_i = addr; d_wdata_i = wd; d_signed_i = sg;
      f_req_i = freq; f_half_i = fh; f_addr_i = faddr;
      #1;

      m = (exp_mode == 3) ? 0 : exp_mode;   // R8: spare code acts as little-endian
      wtag = (m == 2) ? "R2 store lanes" : (m == 1) ? "R3 store lanes" : "R1 store lanes";
      bad = dreq && is_bad(sz, addr);
      go  = dreq && !bad;
      chk_eq("R6 misalign flag", {31'b0, d_misalign_o}, {31'b0, bad});
      chk_eq("R6 memory request", {31'b0, m_req_o}, {31'b0, go});
      if (go) begin
         chk_eq("R4 word address", m_addr_o, addr & ~32'd3);
         chk_eq("R4 strobes", {28'b0, m_be_o}, ref_be(m, sz, addr));
         if (we) chk_eq(wtag, m_wdata_o, ref_wd(m, sz, addr, wd));
      end
      pend_d = go && !we;
      if (pend_d) exp_d = ref_ld(m, sz, addr, sg, mem[(addr >> 2) & 15], 0);

      fsz  = fh ? 1 : 2;
      fbad = freq && is_bad(fsz, faddr);
      fgo  = freq && !fbad;
      chk_eq("R7 fetch misalign", {31'b0, f_misalign_o}, {31'b0, fbad});
      chk_eq("R7 fetch request", {31'b0, i_req_o}, {31'b0, fgo});
      if (fgo) chk_eq("R7 fetch address", i_addr_o, faddr & ~32'd3);
      pend_f = fgo;
      if (pend_f) exp_f = ref_ld(m, fsz, faddr, 0, mem[(faddr >> 2) & 15], 1);

      if (!dreq && !freq && !prev_busy) exp_mode = mode;   // R8
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 32'h0F1E2D3C + i * 32'h11131517;
      rst_n = 0; mode_i = 0; d_req_i = 0; d_we_i = 0; d_size_i = 0; d_signed_i = 0;
      d_addr_i = 0; d_wdata_i = 0; f_req_i = 0; f_half_i = 0; f_addr_i = 0;
      m_rdata_i = 0; i_rdata_i = 0;
      repeat (3) @(negedge clk);
      // R9: idle outputs during reset
      chk_eq("R9 reset load valid", {31'b0, d_rvalid_o}, 32'd0);
      chk_eq("R9 reset fetch valid", {31'b0, f_ivalid_o}, 32'd0);
      chk_eq("R9 reset memory request", {31'b0, m_req_o | i_req_o}, 32'd0);
      rst_n = 1;
      @(negedge clk);

      // R9/R8: mode 10 shown in a request cycle is not taken; little-endian applies
      step(2, 1, 1, 1, 0, 32'h0000BEEF, 0, 0, 0, 0);
      chk_eq("R9 little-endian after reset", m_wdata_o, 32'h0000BEEF);
      step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);                // idle: mode 10 taken
      step(2, 1, 1, 2, 16, 32'h12345678, 0, 0, 0, 0);
      chk_eq("R2 reversed word store", m_wdata_o, 32'h78563412);
      // load and fetch of the same word in one cycle
      step(2, 1, 0, 2, 16, 0, 0, 1, 0, 16);
      chk_eq("R2 word load restored", d_rdata_o, 32'h12345678);
      chk_eq("R7 fetch not reversed", f_instr_o, 32'h78563412);
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);                // response due: not taken
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);                // idle: mode 01 taken
      step(1, 1, 1, 0, 32, 32'h000000AB, 0, 0, 0, 0);
      chk_eq("R3 byte lane mirrored", {28'b0, m_be_o}, 32'h8);
      chk_eq("R3 byte data", m_wdata_o, 32'hAB000000);
      step(1, 1, 0, 1, 34, 0, 1, 1, 1, 34);
      step(0, 1, 0, 2, 32, 0, 0, 1, 0, 32);              // word passes, mode not taken
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);                // little-endian taken
      step(0, 1, 1, 1, 42, 32'h00008001, 0, 0, 0, 0);
      chk_eq("R1 halfword strobes", {28'b0, m_be_o}, 32'hC);
      step(0, 1, 0, 1, 42, 0, 1, 0, 0, 0);
      chk_eq("R5 sign extended", d_rdata_o, 32'hFFFF8001);
      step(0, 1, 0, 1, 42, 0, 0, 0, 0, 0);
      chk_eq("R5 zero extended", d_rdata_o, 32'h00008001);
      step(0, 1, 0, 1, 43, 0, 0, 1, 1, 5);               // R6 and R7 misaligned
      step(0, 1, 1, 3, 8, 32'hFFFFFFFF, 0, 1, 0, 6);
      step(3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(3, 1, 1, 2, 20, 32'hCAFEF00D, 0, 0, 0, 0);    // R8: spare code as little-endian

      for (int it = 0; it < 800; it++) begin
         int md = (($urandom_range(0, 9) < 3) ? $urandom_range(0, 3) : exp_mode);
         bit dq = ($urandom_range(0, 9) < 6);
         bit fq = ($urandom_range(0, 9) < 4);
         int sz = ($urandom_range(0, 19) == 0) ? 3 : $urandom_range(0, 2);
         step(md, dq, $urandom_range(0, 1) == 1, sz, $urandom_range(0, 63), $urandom(),
              $urandom_range(0, 1) == 1, fq, $urandom_range(0, 1) == 1, $urandom_range(0, 63));
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      report();
   end
endmodule